// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time as packed BCD bytes: seconds, minutes, hours (24-hour), day of week, date, month, year and century. A one-cycle pulse on the 1 Hz tick input advances the time by one second. Every field rolls over at its limit. Month length and the leap-year rule set the end of each month, and a year rollover from 99 carries into the century byte.

A host reads and writes single bytes at register offsets. A transfer-enable bit in the second control register sets what the host sees. When the bit is 1, the host view tracks the running counters. When the bit is 0, the host view freezes so that a multi-byte read is coherent, while the counters keep running. Host writes made during a freeze are staged. Setting the bit back to 1 loads the fields that were written into the counters in one cycle, and leaves the other fields running. The running time is also driven out as a 64-bit bus for the alarm and watchdog blocks.

Top module: `bcd_calendar`

## Requirements
- R1: After reset every register reads 0x00 except date (offset 0x4) and month (offset 0x5), which read 0x01. Both control registers read 0x00.
- R2: Each cycle with `tick_1hz` high advances the seconds by one in BCD. The running time does not change without a tick or a write. `time_bcd` byte k holds the field at offset k (seconds at 0x0, minutes 0x1, hours 0x2, day of week 0x3, date 0x4, month 0x5, year 0x6, century 0x7).
- R3: Read data appears on `rdata` in the cycle after `addr` is presented. While the transfer-enable bit (bit 7 of control register 2 at offset 0xF) is 1, the time registers read the running time.
- R4: While transfer-enable is 0, the time registers read a frozen copy, and `time_bcd` keeps advancing on ticks.
- R5: A time write made while transfer-enable is 0 reads back at once but leaves `time_bcd` unchanged. A write of 1 to transfer-enable then loads only the written fields into the counters, in the same clock edge.
- R6: A time write made while transfer-enable is 1 changes the running counter at that clock edge.
- R7: Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps and carries into hours. Hours 23 wraps to 00 and advances the date and the day of week. The day of week counts 1 to 7 and wraps to 1.
- R8: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months except February. February ends at 29 when the full year is a leap year and at 28 otherwise. A year is a leap year when the two-digit year is a non-zero multiple of 4, or when the year is 00 and the century is a multiple of 4.
- R9: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and increments the century in BCD. Century 99 wraps to 00.
- R10: Writes keep only each field's valid bits: 7 for seconds and minutes, 6 for hours and date, 3 for day of week, 5 for month, 8 for year and century. Bits 7:5 of the month register hold whatever the host writes there. Counting never changes them, and they do not appear on `time_bcd`.
- R11: Control registers 1 (offset 0xE) and 2 (offset 0xF) are plain read/write bytes. This includes the backup-mode flag at bit 5 of offset 0xF. Offsets 0x8 to 0xD read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Host write strobe for this cycle |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data for the previous cycle's `addr` |
| time_bcd | output | 64 | Running time, one BCD byte per field, byte k = offset k |

## Verification
The assertions assume that `wr_en` and `tick_1hz` are each one-cycle pulses. The counter-stability property applies only in cycles with neither a tick nor a write. The seconds-wrap property requires that no write coincides with the tick. The century property treats any write in the previous cycle as a legitimate cause of change. The directed stimulus drives inputs on the falling clock edge and keeps every write and every tick as a separate single-cycle pulse, so each property meets its assumption.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W = 8;
  localparam int NFLD   = 8;
  localparam int ADDR_W = 4;
  localparam int FLD_IW = $clog2(NFLD);
  localparam int MON_W  = 5;
  localparam int TE_BIT = 7;

  localparam int IX_SEC  = 0;
  localparam int IX_MIN  = 1;
  localparam int IX_HOUR = 2;
  localparam int IX_DOW  = 3;
  localparam int IX_DATE = 4;
  localparam int IX_MON  = 5;
  localparam int IX_YEAR = 6;
  localparam int IX_CENT = 7;

  localparam logic [ADDR_W-1:0] OFF_CTLA = 4'hE;
  localparam logic [ADDR_W-1:0] OFF_CTLB = 4'hF;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [NFLD-1:0][BYTE_W-1:0] cal_t;

  function automatic byte_t fld_mask(int idx);
    case (idx)
      IX_SEC, IX_MIN:   return 8'h7F;
      IX_HOUR, IX_DATE: return 8'h3F;
      IX_DOW:           return 8'h07;
      IX_MON:           return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction

  function automatic cal_t cal_reset();
    cal_t r;
    r = '0;
    r[IX_DATE] = 8'h01;
    r[IX_MON]  = 8'h01;
    return r;
  endfunction

  function automatic byte_t bcd_inc(byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic int bcd2bin(byte_t v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic int month_len(byte_t mon, byte_t yr, byte_t cen);
    int  m;
    int  y;
    int  c;
    logic leap;
    m = bcd2bin(mon);
    y = bcd2bin(yr);
    c = bcd2bin(cen);
    leap = (y == 0) ? ((c % 4) == 0) : ((y % 4) == 0);
    case (m)
      2:           return leap ? 29 : 28;
      4, 6, 9, 11: return 30;
      default:     return 31;
    endcase
  endfunction
endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  logic step,
  input  cal_t cur,
  output cal_t nxt
);
  logic c_min, c_hour, c_day, c_mon, c_year, c_cent;

  always_comb begin
    nxt    = cur;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    c_cent = 1'b0;
    if (step) begin
      if (cur[IX_SEC] >= 8'h59) begin
        nxt[IX_SEC] = 8'h00;
        c_min = 1'b1;
      end else nxt[IX_SEC] = bcd_inc(cur[IX_SEC]);
    end
    if (c_min) begin
      if (cur[IX_MIN] >= 8'h59) begin
        nxt[IX_MIN] = 8'h00;
        c_hour = 1'b1;
      end else nxt[IX_MIN] = bcd_inc(cur[IX_MIN]);
    end
    if (c_hour) begin
      if (cur[IX_HOUR] >= 8'h23) begin
        nxt[IX_HOUR] = 8'h00;
        c_day = 1'b1;
      end else nxt[IX_HOUR] = bcd_inc(cur[IX_HOUR]);
    end
    if (c_day) begin
      nxt[IX_DOW] = (cur[IX_DOW] >= 8'h07) ? 8'h01 : cur[IX_DOW] + 8'h01;
      if (bcd2bin(cur[IX_DATE]) >= month_len(cur[IX_MON], cur[IX_YEAR], cur[IX_CENT])) begin
        nxt[IX_DATE] = 8'h01;
        c_mon = 1'b1;
      end else nxt[IX_DATE] = bcd_inc(cur[IX_DATE]);
    end
    if (c_mon) begin
      if (cur[IX_MON] >= 8'h12) begin
        nxt[IX_MON] = 8'h01;
        c_year = 1'b1;
      end else nxt[IX_MON] = bcd_inc(cur[IX_MON]);
    end
    if (c_year) begin
      if (cur[IX_YEAR] >= 8'h99) begin
        nxt[IX_YEAR] = 8'h00;
        c_cent = 1'b1;
      end else nxt[IX_YEAR] = bcd_inc(cur[IX_YEAR]);
    end
    if (c_cent) begin
      nxt[IX_CENT] = (cur[IX_CENT] >= 8'h99) ? 8'h00 : bcd_inc(cur[IX_CENT]);
    end
  end
endmodule

// File: rtl/cal_host_port.sv
module cal_host_port
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  cal_t              view,
  input  logic [BYTE_W-MON_W-1:0] mon_hi,
  input  byte_t             ctla,
  input  byte_t             ctlb,
  output byte_t             rdata
);
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (int'(addr) < NFLD) begin
      if (int'(addr) == IX_MON) rdata <= {mon_hi, view[IX_MON][MON_W-1:0]};
      else                      rdata <= view[addr[FLD_IW-1:0]];
    end
    else if (addr == OFF_CTLA) rdata <= ctla;
    else if (addr == OFF_CTLB) rdata <= ctlb;
    else                       rdata <= '0;
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_1hz,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [BYTE_W-1:0]       rdata,
  output logic [NFLD*BYTE_W-1:0]  time_bcd
);
  cal_t  run_q, host_q, merged, run_nxt;
  logic [NFLD-1:0] dirty_q;
  byte_t ctla_q, ctlb_q;
  logic [BYTE_W-MON_W-1:0] mon_hi_q;

  logic te, te_nxt, wr_fld, commit;
  logic [FLD_IW-1:0] fld_idx;
  byte_t wval;

  assign te      = ctlb_q[TE_BIT];
  assign wr_fld  = wr_en && (int'(addr) < NFLD);
  assign fld_idx = addr[FLD_IW-1:0];
  assign wval    = wdata & fld_mask(int'(fld_idx));
  assign commit  = wr_en && (addr == OFF_CTLB) && !te && wdata[TE_BIT];
  assign te_nxt  = (wr_en && addr == OFF_CTLB) ? wdata[TE_BIT] : te;

  always_comb begin
    for (int i = 0; i < NFLD; i++) begin
      if (commit && dirty_q[i])                        merged[i] = host_q[i];
      else if (wr_fld && te && int'(fld_idx) == i)     merged[i] = wval;
      else                                             merged[i] = run_q[i];
    end
  end

  cal_advance u_adv (
    .step (tick_1hz),
    .cur  (merged),
    .nxt  (run_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= cal_reset();
      host_q   <= cal_reset();
      dirty_q  <= '0;
      ctla_q   <= '0;
      ctlb_q   <= '0;
      mon_hi_q <= '0;
    end else begin
      run_q <= run_nxt;
      if (wr_en && addr == OFF_CTLA) ctla_q <= wdata;
      if (wr_en && addr == OFF_CTLB) ctlb_q <= wdata;
      if (wr_en && int'(addr) == IX_MON) mon_hi_q <= wdata[BYTE_W-1:MON_W];
      if (te_nxt)              host_q <= run_nxt;
      else if (wr_fld && !te)  host_q[fld_idx] <= wval;
      if (te_nxt)              dirty_q <= '0;
      else if (wr_fld && !te)  dirty_q[fld_idx] <= 1'b1;
    end
  end

  cal_host_port u_port (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .view   (host_q),
    .mon_hi (mon_hi_q),
    .ctla   (ctla_q),
    .ctlb   (ctlb_q),
    .rdata  (rdata)
  );

  assign time_bcd = run_q;
endmodule

// File: rtl/cal_chk.sv
module cal_chk
  import cal_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic tick,
  input logic wr_en,
  input logic te,
  input cal_t run,
  input cal_t host,
  input logic [BYTE_W-MON_W-1:0] mon_hi
);
  // R3
  host_tracks_run_chk: assert property (@(posedge clk) disable iff (rst)
    te |-> (host == run));

  // R4
  host_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!te && !wr_en) |=> $stable(host));

  // R2
  run_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable(run));

  // R7
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && run[IX_SEC] == 8'h59) |=> (run[IX_SEC] == 8'h00));

  // R9
  cent_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(run[IX_CENT]) |-> ($past(run[IX_YEAR]) == 8'h99 || $past(wr_en)));

  // R10
  mon_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mon_hi));
endmodule

bind bcd_calendar cal_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick_1hz),
  .wr_en  (wr_en),
  .te     (ctlb_q[TE_BIT]),
  .run    (run_q),
  .host   (host_q),
  .mon_hi (mon_hi_q)
);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [63:0] time_bcd;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bcd_calendar dut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .time_bcd(time_bcd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  function automatic logic [7:0] fb(input int k);
    return time_bcd[k*8 +: 8];
  endfunction

  task automatic set_all(input logic [7:0] cen, yr, mon, date, dow, hr, mn, sc);
    wr(4'hF, 8'h00);
    wr(4'h7, cen); wr(4'h6, yr); wr(4'h5, mon); wr(4'h4, date);
    wr(4'h3, dow); wr(4'h2, hr); wr(4'h1, mn); wr(4'h0, sc);
    wr(4'hF, 8'h80);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int k = 0; k < 8; k++) begin
      rd(4'(k), d);
      chk("R1 reset field", d, (k == 4 || k == 5) ? 8'h01 : 8'h00);
    end
    rd(4'hE, d); chk("R1 reset ctl1", d, 8'h00);
    rd(4'hF, d); chk("R1 reset ctl2", d, 8'h00);
    chk("R1 reset time_bcd", time_bcd, 64'h0000_0101_0000_0000);
    chk("R2 no change without tick", time_bcd, 64'h0000_0101_0000_0000);
  endtask

  task automatic t_tick();
    logic [7:0] d;
    set_all(8'h20, 8'h24, 8'h06, 8'h15, 8'h02, 8'h12, 8'h34, 8'h56);
    chk("R5 commit loads all written", time_bcd, 64'h2024_0615_0212_3456);
    tick();
    chk("R2 sec step", fb(0), 8'h57);
    chk("R2 min untouched", fb(1), 8'h34);
    rd(4'h0, d); chk("R3 host tracks", d, 8'h57);
  endtask

  task automatic t_roll();
    set_all(8'h19, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    tick();
    chk("R7 R9 full rollover", time_bcd, 64'h2000_0101_0100_0000);
    set_all(8'h99, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
    tick();
    chk("R9 century wraps", fb(7), 8'h00);
    chk("R7 dow step", fb(3), 8'h04);
    set_all(8'h20, 8'h24, 8'h03, 8'h10, 8'h02, 8'h09, 8'h59, 8'h59);
    tick();
    chk("R7 minute carry to hour", fb(2), 8'h10);
    chk("R7 minute wraps", fb(1), 8'h00);
  endtask

  task automatic day_case(input string tag, input logic [7:0] cen, yr, mon, date,
                          input logic [7:0] emon, edate);
    set_all(cen, yr, mon, date, 8'h03, 8'h23, 8'h59, 8'h59);
    tick();
    chk({"R8 month ", tag}, fb(5), emon);
    chk({"R8 date ", tag}, fb(4), edate);
  endtask

  task automatic t_months();
    day_case("leap 2024", 8'h20, 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    day_case("feb29 end", 8'h20, 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    day_case("common 2023", 8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    day_case("cent 2100", 8'h21, 8'h00, 8'h02, 8'h28, 8'h03, 8'h01);
    day_case("cent 2000", 8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
    day_case("apr 30", 8'h20, 8'h25, 8'h04, 8'h30, 8'h05, 8'h01);
    day_case("apr 29", 8'h20, 8'h25, 8'h04, 8'h29, 8'h04, 8'h30);
    day_case("jan 31", 8'h20, 8'h25, 8'h01, 8'h31, 8'h02, 8'h01);
  endtask

  task automatic t_freeze();
    logic [7:0] d;
    set_all(8'h20, 8'h24, 8'h06, 8'h15, 8'h02, 8'h10, 8'h20, 8'h30);
    wr(4'hF, 8'h00);
    tick(); tick(); tick();
    rd(4'h0, d); chk("R4 host frozen", d, 8'h30);
    chk("R4 counter runs", fb(0), 8'h33);
    wr(4'h1, 8'h45);
    rd(4'h1, d); chk("R5 staged readback", d, 8'h45);
    chk("R5 counter untouched", fb(1), 8'h20);
    wr(4'hF, 8'h80);
    chk("R5 written field loaded", fb(1), 8'h45);
    chk("R5 unwritten field kept", fb(0), 8'h33);
    rd(4'h0, d); chk("R3 resume tracking", d, 8'h33);
  endtask

  task automatic t_direct();
    logic [7:0] d;
    wr(4'h2, 8'h07);
    chk("R6 direct write", fb(2), 8'h07);
    rd(4'h2, d); chk("R6 direct readback", d, 8'h07);
  endtask

  task automatic t_masks();
    logic [7:0] d;
    wr(4'h0, 8'hFF); rd(4'h0, d); chk("R10 sec mask", d, 8'h7F);
    wr(4'h0, 8'h00);
    wr(4'h3, 8'hFF); rd(4'h3, d); chk("R10 dow mask", d, 8'h07);
    wr(4'h5, 8'hE5); rd(4'h5, d); chk("R10 month upper kept", d, 8'hE5);
    chk("R10 month bus value", fb(5), 8'h05);
    tick();
    rd(4'h5, d); chk("R10 upper kept after tick", d, 8'hE5);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    logic [63:0] snap;
    wr(4'hE, 8'h5A); rd(4'hE, d); chk("R11 ctl1 rw", d, 8'h5A);
    wr(4'hF, 8'hA0); rd(4'hF, d); chk("R11 ctl2 rw backup bit", d, 8'hA0);
    snap = time_bcd;
    wr(4'h9, 8'hFF); rd(4'h9, d); chk("R11 unmapped reads zero", d, 8'h00);
    chk("R11 unmapped write no effect", time_bcd, snap);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tick();
    t_roll();
    t_months();
    t_freeze();
    t_direct();
    t_masks();
    t_ctrl();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule